// File: doc/BRIEF.md
# Two-Level Network Route Selector

This block makes the per-hop routing decision for one input of a switch in a two-tier direct-connect network. Hubs are grouped; the hubs of a group are fully connected by local links, and groups are fully connected by global links. On the head flit of every packet, the selector works out which group the packet is heading for at this hop. It then reads either a local table, indexed by destination hub, or a global table, indexed by target group, and registers the chosen output port. Packets injected by the local host interface use one pair of tables. Packets arriving from a link use a second pair.

The header carries a route mode. The direct modes go straight to the destination group. Multiple-direct alternates between two stored global ports for each injecting source. The indirect modes send the packet through one intermediate group. At injection that group is chosen, by round-robin or by a pseudo-random sequence, from the groups other than the source group and the destination group. A phase bit in the header is set when the packet reaches the intermediate group, and from then on the route is direct. Routing is cut-through wormhole: every body flit takes the port locked by its head until the last flit has passed. A missing table entry sends the packet to a discard port and raises a sticky error flag.

Top module: `hier_route_sel`

## Requirements
- R1: After reset, out_valid and err_flag are low. A flit presented with in_valid appears one cycle later with out_valid high, and with out_head and out_last copied from the input.
- R2: A table write with tbl_we high stores tbl_ok, tbl_port_a and tbl_port_b at index tbl_idx of the table that tbl_sel names (0 host-local, 1 host-global, 2 hop-local, 3 hop-global). It affects only that table, and it takes effect for heads presented after the write edge.
- R3: If the target group equals MY_GROUP, the head reads the local table at in_dst_hub; otherwise it reads the global table at the target group. Host tables serve in_from_host=1, hop tables serve in_from_host=0. The route mode is 2 bits: 0 single direct, 1 multiple direct, 2 indirect round-robin, 3 indirect random. In modes 0 and 1 the target is in_dst_group, and out_mid_group and out_phase copy the header.
- R4: In mode 1, host-injected heads that read the global table alternate between port A and port B, per source, starting with A. Hop heads and local lookups use port A.
- R5: A host-injected head in mode 2 or 3 whose in_dst_group differs from MY_GROUP takes candidate k as its intermediate group. The candidates are the GROUPS-2 groups other than MY_GROUP and in_dst_group, in ascending order. The head is routed by the host-global entry of that group, with out_phase 0. If in_dst_group equals MY_GROUP, it is routed as direct.
- R6: In mode 2, k is a per-source pointer that starts at 0 after reset and advances by one, modulo GROUPS-2, on each such head from that source.
- R7: In mode 3, k is (L[7:0] * (GROUPS-2)) >> 8, where L is a 16-bit shift register. L is seeded with 0xACE1 at reset and advances once per such head: shift left, with bit 15 ^ bit 13 ^ bit 12 ^ bit 10 entering bit 0.
- R8: A hop head in mode 2 or 3 with out-of-group destination and phase 0 targets in_mid_group, unless in_mid_group equals MY_GROUP; in that case out_phase becomes 1 and the target is in_dst_group. With phase 1 the target is in_dst_group.
- R9: Body flits ignore their header fields and take the head's port, across idle cycles, until the flit marked last. out_mid_group and out_phase hold the head's values.
- R10: A head whose table entry is marked invalid goes to port NUM_PORTS (discard) and sets err_flag. Its body flits follow it to the discard port.
- R11: A body flit arriving with no open packet goes to the discard port and sets err_flag.
- R12: err_flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 host-local, 1 host-global, 2 hop-local, 3 hop-global |
| tbl_idx | input | max(clog2 GROUPS, clog2 HUBS) | Entry index |
| tbl_ok | input | 1 | Entry valid bit |
| tbl_port_a | input | clog2(NUM_PORTS+1) | Primary port |
| tbl_port_b | input | clog2(NUM_PORTS+1) | Alternate port (global tables) |
| in_valid | input | 1 | Flit present |
| in_head | input | 1 | Flit is a head |
| in_last | input | 1 | Flit ends the packet |
| in_from_host | input | 1 | Packet injected by the local host interface |
| in_src | input | clog2(NUM_SRC) | Injecting source index |
| in_mode | input | 2 | Header route mode |
| in_phase | input | 1 | Header phase bit (intermediate reached) |
| in_dst_group | input | clog2 GROUPS | Destination group |
| in_dst_hub | input | clog2 HUBS | Destination hub within its group |
| in_mid_group | input | clog2 GROUPS | Header intermediate group |
| out_valid | output | 1 | Registered flit present |
| out_head | output | 1 | Registered head marker |
| out_last | output | 1 | Registered last marker |
| out_port | output | clog2(NUM_PORTS+1) | Selected output port |
| out_mid_group | output | clog2 GROUPS | Intermediate group for the rewritten header |
| out_phase | output | 1 | Phase bit for the rewritten header |
| err_flag | output | 1 | Sticky routing error |

## Verification
The assertions check properties that must hold on every cycle. Each flit appears one cycle later. An intermediate chosen at injection is never the own group or the destination group and is in range. A set phase bit is never cleared. Body flits keep the port of their open packet. The error flag only rises together with a discard and never falls. The exact port values, the alternation order, the round-robin and pseudo-random sequences and the table-select decoding can only be shown by the bench. It sweeps every destination group and hub, every phase and intermediate combination, and the injecting sources in both indirect modes, and compares each result with values it computes arithmetically.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_MULTI    = 2'd1,
    MODE_IND_RR   = 2'd2,
    MODE_IND_RAND = 2'd3
  } route_mode_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/rsel_table.sv
module rsel_table #(
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wok,
  input  logic [PW-1:0] wa,
  input  logic [PW-1:0] wb,
  input  logic [IW-1:0] ridx,
  output logic          rok,
  output logic [PW-1:0] ra,
  output logic [PW-1:0] rb
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // port fields carry no reset so they map onto distributed RAM
  logic [PW-1:0]    mem_a [DEPTH];
  logic [PW-1:0]    mem_b [DEPTH];
  logic [DEPTH-1:0] ok_q;
  logic             w_in, r_in;

  assign w_in = {1'b0, widx} < (IW+1)'(DEPTH);
  assign r_in = {1'b0, ridx} < (IW+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (we && w_in) begin
      mem_a[widx[AW-1:0]] <= wa;
      mem_b[widx[AW-1:0]] <= wb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ok_q <= '0;
    else if (we && w_in)  ok_q[widx[AW-1:0]] <= wok;
  end

  assign rok = r_in && ok_q[ridx[AW-1:0]];
  assign ra  = mem_a[ridx[AW-1:0]];
  assign rb  = mem_b[ridx[AW-1:0]];
endmodule

// File: rtl/rsel_mid_pick.sv
module rsel_mid_pick import rsel_pkg::*; #(
  parameter int GROUPS   = 8,
  parameter int NUM_SRC  = 2,
  parameter int MY_GROUP = 0,
  parameter int GW       = 3,
  parameter int SW       = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_rr,
  input  logic          adv_rand,
  input  logic          use_rand,
  input  logic [SW-1:0] src,
  input  logic [GW-1:0] dst_group,
  output logic [GW-1:0] mid_group
);
  localparam int NCAND = GROUPS - 2;
  localparam int KW    = (NCAND > 1) ? $clog2(NCAND) : 1;
  localparam logic [GW-1:0] MY_G = GW'(MY_GROUP);

  logic [KW-1:0] ptr_q [NUM_SRC];
  logic [15:0]   lfsr_q;
  logic [KW-1:0] k;
  logic [GW-1:0] lo, hi, g;
  logic          src_ok;

  assign src_ok = {1'b0, src} < (SW+1)'(NUM_SRC);

  always_comb begin
    if (use_rand)    k = KW'((32'(lfsr_q[7:0]) * 32'(NCAND)) >> 8);
    else if (src_ok) k = ptr_q[src];
    else             k = '0;
  end

  // k-th group in ascending order, skipping the own and destination groups
  always_comb begin
    lo = (dst_group < MY_G) ? dst_group : MY_G;
    hi = (dst_group < MY_G) ? MY_G : dst_group;
    g  = GW'(k);
    if (g >= lo) g = g + 1'b1;
    if (g >= hi) g = g + 1'b1;
    mid_group = g;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) ptr_q[i] <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      if (adv_rr && src_ok)
        ptr_q[src] <= (ptr_q[src] == KW'(NCAND - 1)) ? '0 : ptr_q[src] + 1'b1;
      if (adv_rand)
        lfsr_q <= lfsr_step(lfsr_q);
    end
  end
endmodule

// File: rtl/hier_route_sel.sv
module hier_route_sel import rsel_pkg::*; #(
  parameter int GROUPS    = 8,
  parameter int HUBS      = 4,
  parameter int NUM_PORTS = 12,
  parameter int NUM_SRC   = 2,
  parameter int MY_GROUP  = 2,
  localparam int GW   = $clog2(GROUPS),
  localparam int HW   = $clog2(HUBS),
  localparam int PW   = $clog2(NUM_PORTS + 1),
  localparam int SW   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int IDXW = (GW > HW) ? GW : HW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tbl_we,
  input  logic [1:0]      tbl_sel,
  input  logic [IDXW-1:0] tbl_idx,
  input  logic            tbl_ok,
  input  logic [PW-1:0]   tbl_port_a,
  input  logic [PW-1:0]   tbl_port_b,
  input  logic            in_valid,
  input  logic            in_head,
  input  logic            in_last,
  input  logic            in_from_host,
  input  logic [SW-1:0]   in_src,
  input  logic [1:0]      in_mode,
  input  logic            in_phase,
  input  logic [GW-1:0]   in_dst_group,
  input  logic [HW-1:0]   in_dst_hub,
  input  logic [GW-1:0]   in_mid_group,
  output logic            out_valid,
  output logic            out_head,
  output logic            out_last,
  output logic [PW-1:0]   out_port,
  output logic [GW-1:0]   out_mid_group,
  output logic            out_phase,
  output logic            err_flag
);
  localparam logic [GW-1:0] MY_G    = GW'(MY_GROUP);
  localparam logic [PW-1:0] DISCARD = PW'(NUM_PORTS);

  route_mode_e   mode;
  logic          head_fire, body_fire, indirect, src_ok;
  logic [GW-1:0] tgt, nx_mid, picked;
  logic          nx_phase, want_rr, want_rand, is_local;
  logic          hit_ok, use_b, tog_adv;
  logic [PW-1:0] hit_port, head_port;
  logic [3:0]    rd_ok;
  logic [PW-1:0] rd_a [4];
  logic [PW-1:0] rd_b [4];
  logic [1:0]    tsel;
  logic [NUM_SRC-1:0] tog_q;
  logic          lock_open_q;
  logic [PW-1:0] lock_port_q;

  assign mode      = route_mode_e'(in_mode);
  assign head_fire = in_valid && in_head;
  assign body_fire = in_valid && !in_head;
  assign indirect  = in_mode[1];
  assign src_ok    = {1'b0, in_src} < (SW+1)'(NUM_SRC);

  // target group for this hop and the rewritten header fields
  always_comb begin
    tgt       = in_dst_group;
    nx_mid    = in_mid_group;
    nx_phase  = in_phase;
    want_rr   = 1'b0;
    want_rand = 1'b0;
    if (indirect && in_dst_group != MY_G) begin
      if (in_from_host) begin
        nx_mid    = picked;
        nx_phase  = 1'b0;
        tgt       = picked;
        want_rr   = (mode == MODE_IND_RR);
        want_rand = (mode == MODE_IND_RAND);
      end else if (!in_phase) begin
        if (in_mid_group == MY_G) nx_phase = 1'b1;
        else                      tgt      = in_mid_group;
      end
    end
  end

  rsel_mid_pick #(
    .GROUPS(GROUPS), .NUM_SRC(NUM_SRC), .MY_GROUP(MY_GROUP), .GW(GW), .SW(SW)
  ) u_pick (
    .clk       (clk),
    .rst       (rst),
    .adv_rr    (head_fire && want_rr),
    .adv_rand  (head_fire && want_rand),
    .use_rand  (mode == MODE_IND_RAND),
    .src       (in_src),
    .dst_group (in_dst_group),
    .mid_group (picked)
  );

  // table t: bit 1 = hop (not host), bit 0 = global
  for (genvar t = 0; t < 4; t++) begin : g_tbl
    localparam int DEPTH = (t % 2 == 1) ? GROUPS : HUBS;
    logic [IDXW-1:0] ridx;
    assign ridx = (t % 2 == 1) ? IDXW'(tgt) : IDXW'(in_dst_hub);
    rsel_table #(.DEPTH(DEPTH), .IW(IDXW), .PW(PW)) u_tbl (
      .clk  (clk),
      .rst  (rst),
      .we   (tbl_we && tbl_sel == 2'(t)),
      .widx (tbl_idx),
      .wok  (tbl_ok),
      .wa   (tbl_port_a),
      .wb   (tbl_port_b),
      .ridx (ridx),
      .rok  (rd_ok[t]),
      .ra   (rd_a[t]),
      .rb   (rd_b[t])
    );
  end

  always_comb begin
    is_local  = (tgt == MY_G);
    tsel      = {!in_from_host, !is_local};
    tog_adv   = in_from_host && (mode == MODE_MULTI) && !is_local && src_ok;
    use_b     = tog_adv && tog_q[in_src];
    hit_ok    = rd_ok[tsel];
    hit_port  = use_b ? rd_b[tsel] : rd_a[tsel];
    head_port = hit_ok ? hit_port : DISCARD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_head      <= 1'b0;
      out_last      <= 1'b0;
      out_port      <= '0;
      out_mid_group <= '0;
      out_phase     <= 1'b0;
      err_flag      <= 1'b0;
      lock_open_q   <= 1'b0;
      lock_port_q   <= '0;
      tog_q         <= '0;
    end else begin
      out_valid <= in_valid;
      out_head  <= head_fire;
      out_last  <= in_valid && in_last;
      if (head_fire) begin
        out_port      <= head_port;
        out_mid_group <= nx_mid;
        out_phase     <= nx_phase;
        lock_open_q   <= !in_last;
        lock_port_q   <= head_port;
        if (!hit_ok) err_flag <= 1'b1;
        if (tog_adv) tog_q[in_src] <= !tog_q[in_src];
      end else if (body_fire) begin
        out_port <= lock_open_q ? lock_port_q : DISCARD;
        if (!lock_open_q) err_flag    <= 1'b1;
        if (in_last)      lock_open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hier_route_sel_chk.sv
module hier_route_sel_chk #(
  parameter int GROUPS    = 8,
  parameter int NUM_PORTS = 12,
  parameter int MY_GROUP  = 2,
  localparam int GW = $clog2(GROUPS),
  localparam int PW = $clog2(NUM_PORTS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_head,
  input logic          in_from_host,
  input logic [1:0]    in_mode,
  input logic          in_phase,
  input logic [GW-1:0] in_dst_group,
  input logic          out_valid,
  input logic          out_head,
  input logic          out_last,
  input logic [PW-1:0] out_port,
  input logic [GW-1:0] out_mid_group,
  input logic          out_phase,
  input logic          err_flag
);
  localparam logic [GW-1:0] MY_G    = GW'(MY_GROUP);
  localparam logic [PW-1:0] DISCARD = PW'(NUM_PORTS);

  logic          open_q;
  logic [PW-1:0] port_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      port_q <= '0;
    end else if (out_valid && out_head) begin
      open_q <= !out_last;
      port_q <= out_port;
    end else if (out_valid && out_last) begin
      open_q <= 1'b0;
    end
  end

  // R1
  flit_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R5
  mid_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_head && in_from_host && in_mode[1] && in_dst_group != MY_G)
    |=> (out_mid_group != MY_G && out_mid_group != $past(in_dst_group)
         && {1'b0, out_mid_group} < (GW+1)'(GROUPS)));
  // R8
  phase_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_head && !in_from_host && in_phase) |=> out_phase);
  // R9
  body_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_head && open_q) |-> out_port == port_q);
  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (out_valid && out_port == DISCARD));
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind hier_route_sel hier_route_sel_chk #(
  .GROUPS(GROUPS), .NUM_PORTS(NUM_PORTS), .MY_GROUP(MY_GROUP)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_head       (in_head),
  .in_from_host  (in_from_host),
  .in_mode       (in_mode),
  .in_phase      (in_phase),
  .in_dst_group  (in_dst_group),
  .out_valid     (out_valid),
  .out_head      (out_head),
  .out_last      (out_last),
  .out_port      (out_port),
  .out_mid_group (out_mid_group),
  .out_phase     (out_phase),
  .err_flag      (err_flag)
);

// File: tb/hier_route_sel_tb.sv
`timescale 1ns/1ps
module hier_route_sel_tb;
  localparam int G = 8, H = 4, NP = 12, NS = 2, MY = 2, NC = G - 2;
  localparam int GW = 3, HW = 2, PW = 4, SW = 1, IDXW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic tbl_we = 1'b0, tbl_ok = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic [IDXW-1:0] tbl_idx = '0;
  logic [PW-1:0] tbl_port_a = '0, tbl_port_b = '0;
  logic in_valid = 1'b0, in_head = 1'b0, in_last = 1'b0, in_from_host = 1'b0, in_phase = 1'b0;
  logic [SW-1:0] in_src = '0;
  logic [1:0] in_mode = '0;
  logic [GW-1:0] in_dst_group = '0, in_mid_group = '0;
  logic [HW-1:0] in_dst_hub = '0;
  logic out_valid, out_head, out_last, out_phase, err_flag;
  logic [PW-1:0] out_port;
  logic [GW-1:0] out_mid_group;

  always #2 clk = ~clk;

  hier_route_sel #(.GROUPS(G), .HUBS(H), .NUM_PORTS(NP), .NUM_SRC(NS), .MY_GROUP(MY)) u_dut (
    .clk, .rst, .tbl_we, .tbl_sel, .tbl_idx, .tbl_ok, .tbl_port_a, .tbl_port_b,
    .in_valid, .in_head, .in_last, .in_from_host, .in_src, .in_mode, .in_phase,
    .in_dst_group, .in_dst_hub, .in_mid_group,
    .out_valid, .out_head, .out_last, .out_port, .out_mid_group, .out_phase, .err_flag);

  int n_chk = 0, n_fail = 0;
  int ma [4][8];
  int mb [4][8];
  bit mok [4][8];
  int ptr_m [NS];
  bit tog_m [NS];
  logic [15:0] lfsr_m;
  bit err_m, lock_m, eph_m;
  int lport_m, emid_m;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fa(int t, int i); return (t * 3 + i * 5 + 1) % NP; endfunction
  function automatic int fb(int t, int i); return (t * 3 + i * 7 + 2) % NP; endfunction
  function automatic bit fok(int t, int i); return !((t == 0 && i == 3) || (t == 3 && i == 6)); endfunction

  function automatic int cand(int k, int d);
    int lo, hi, g;
    lo = (d < MY) ? d : MY;
    hi = (d < MY) ? MY : d;
    g = k;
    if (g >= lo) g++;
    if (g >= hi) g++;
    return g;
  endfunction

  task automatic wr(input int t, input int i, input bit ok, input int a, input int b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'(t); tbl_idx = IDXW'(i); tbl_ok = ok;
    tbl_port_a = PW'(a); tbl_port_b = PW'(b);
    @(posedge clk); #1;
    tbl_we = 1'b0;
    ma[t][i] = a; mb[t][i] = b; mok[t][i] = ok;
  endtask

  task automatic program_all();
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < ((t % 2 == 1) ? G : H); i++)
        wr(t, i, fok(t, i), fa(t, i), fb(t, i));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; tbl_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int s = 0; s < NS; s++) begin ptr_m[s] = 0; tog_m[s] = 1'b0; end
    lfsr_m = 16'hACE1; err_m = 0; lock_m = 0; lport_m = 0; emid_m = 0; eph_m = 0;
  endtask

  task automatic predict_head(input bit host, input int src, input int mode, input bit ph,
                              input int dg, input int dh, input int mg,
                              output int ep, output int em, output bit eph);
    int tgt, t, idx, k;
    bit use_b;
    tgt = dg; em = mg; eph = ph;
    if (mode >= 2 && dg != MY) begin
      if (host) begin
        if (mode == 2) begin
          k = ptr_m[src]; ptr_m[src] = (k + 1) % NC;
        end else begin
          k = (int'(lfsr_m[7:0]) * NC) >> 8;
          lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
        end
        em = cand(k, dg); eph = 0; tgt = em;
      end else if (!ph) begin
        if (mg == MY) eph = 1; else tgt = mg;
      end
    end
    t = (host ? 0 : 2) + ((tgt == MY) ? 0 : 1);
    idx = (tgt == MY) ? dh : tgt;
    use_b = 0;
    if (host && mode == 1 && tgt != MY) begin
      use_b = tog_m[src]; tog_m[src] = !tog_m[src];
    end
    if (!mok[t][idx]) begin ep = NP; err_m = 1; end
    else ep = use_b ? mb[t][idx] : ma[t][idx];
  endtask

  task automatic flit(input bit head, input bit last, input bit host, input int src, input int mode,
                      input bit ph, input int dg, input int dh, input int mg, input string tag);
    int ep, em;
    bit eph;
    if (head) begin
      predict_head(host, src, mode, ph, dg, dh, mg, ep, em, eph);
      lport_m = ep; lock_m = !last; emid_m = em; eph_m = eph;
    end else begin
      if (lock_m) ep = lport_m;
      else begin ep = NP; err_m = 1; end
      if (last) lock_m = 0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_head = head; in_last = last; in_from_host = host;
    in_src = SW'(src); in_mode = 2'(mode); in_phase = ph;
    in_dst_group = GW'(dg); in_dst_hub = HW'(dh); in_mid_group = GW'(mg);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(out_valid && out_head == head && out_last == last, {tag, " R1 framing"},
        {out_valid, out_head, out_last}, {1'b1, head, last});
    chk(out_port == PW'(ep), {tag, " port"}, out_port, ep);
    chk(out_mid_group == GW'(emid_m), {tag, " mid"}, out_mid_group, emid_m);
    chk(out_phase == eph_m, {tag, " phase"}, out_phase, eph_m);
    chk(err_flag == err_m, {tag, " err"}, err_flag, err_m);
  endtask

  task automatic idle(input string tag);
    @(posedge clk); #1;
    chk(!out_valid, {tag, " R1 idle"}, out_valid, 0);
  endtask

  initial begin
    do_reset();
    chk(!out_valid, "R1 reset valid", out_valid, 0);
    chk(!err_flag, "R12 reset err", err_flag, 0);
    program_all();

    // R11: stray body, then R12 sticky over a clean packet
    flit(0, 1, 1, 0, 0, 0, 5, 0, 0, "R11 stray body");
    flit(1, 1, 1, 0, 0, 0, 5, 0, 0, "R12 sticky");
    do_reset();
    chk(!err_flag, "R12 cleared by reset", err_flag, 0);
    program_all();

    for (int dg = 0; dg < G; dg++)
      for (int dh = 0; dh < H; dh++)
        flit(1, 1, 1, 0, 0, 0, dg, dh, 0, "R3 host direct/R10");
    for (int dg = 0; dg < G; dg++)
      for (int dh = 0; dh < H; dh++)
        flit(1, 1, 0, 0, 0, 0, dg, dh, 7 - dg, "R3 hop direct/R10");

    for (int n = 0; n < 16; n++)
      flit(1, 1, 1, n % 2, 1, 0, (n * 5) % G, n % H, 0, "R4 multi host");
    flit(1, 1, 0, 0, 1, 0, 5, 0, 0, "R4 multi hop");
    flit(1, 1, 0, 1, 1, 0, 5, 0, 0, "R4 multi hop");

    for (int n = 0; n < 20; n++)
      flit(1, 1, 1, n % 2, 2, n % 2, (n * 3) % G, n % H, 0, "R6 rr/R5");
    for (int n = 0; n < 24; n++)
      flit(1, 1, 1, n % 2, 3, 0, (n * 3 + 1) % G, (n + 1) % H, 0, "R7 random/R5");

    for (int ph = 0; ph < 2; ph++)
      for (int mg = 0; mg < G; mg++)
        for (int dg = 0; dg < G; dg++)
          flit(1, 1, 0, 0, 2 + dg % 2, ph[0], dg, (mg + dg) % H, mg, "R8 hop indirect");

    // R9: wormhole with changing body header fields and idle gaps
    flit(1, 0, 1, 0, 0, 0, 5, 0, 0, "R9 head");
    flit(0, 0, 0, 1, 3, 1, 1, 3, 6, "R9 body");
    idle("R9 gap");
    idle("R9 gap");
    flit(0, 0, 1, 0, 1, 0, MY, 1, 3, "R9 body");
    flit(0, 1, 0, 0, 2, 0, 7, 2, 4, "R9 last");
    flit(1, 0, 0, 0, 2, 0, 4, 0, 1, "R9 head indirect");
    flit(0, 1, 1, 1, 0, 1, 0, 0, 0, "R9 last");
    flit(1, 0, 1, 0, 0, 0, MY, 3, 0, "R10 invalid head");
    flit(0, 0, 1, 0, 0, 0, 4, 0, 0, "R10 body to discard");
    flit(0, 1, 1, 0, 0, 0, 4, 0, 0, "R10 last to discard");

    // R2: rewrites and table-select isolation
    wr(1, 5, 1, 9, 10);
    flit(1, 1, 1, 0, 0, 0, 5, 0, 0, "R2 rewrite host-global");
    wr(2, 1, 1, 11, 0);
    flit(1, 1, 1, 0, 0, 0, MY, 1, 0, "R2 host-local untouched");
    flit(1, 1, 0, 0, 0, 0, MY, 1, 0, "R2 hop-local rewrite");
    wr(1, 5, 0, 9, 10);
    flit(1, 1, 1, 0, 0, 0, 5, 0, 0, "R2 invalidate");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule